// File: doc/BRIEF.md
# Level-Sensitive Scan Clock Sequencer

This block runs one test pattern through a double-latch, level-sensitive scan chain by issuing enable pulses for three separate clocks: a master scan clock (A), a slave clock (B) and a system clock (C). Each pulse lasts one cycle. A start request shifts a pattern into the chain with A-then-B pairs. The sequencer then hands control to the tester twice. First it asks for primary inputs to be applied. Then it holds every clock off while the tester strobes the primary outputs. After that it captures the logic's response into the L1 latches with one C pulse, copies L1 into L2 with a lone B pulse, and shifts the result out with further A/B pairs. A one-cycle done flag closes the run.

The shift length is set per run through a programmable chain length, which is sampled at start. A behavioural model of the L1/L2 latch pairs is included. It responds to the generated enables, takes scan data in and drives scan data out, so a bench can check the whole sequence end to end. The parameter `GAP_CYCLES` sets how many clock-free cycles follow every pulse.

Top module: `lssd_clk_seq`

## Requirements
- R1: After reset, all three clock enables, `pi_apply_o`, `po_strobe_o`, `busy_o` and `done_o` are low.
- R2: A start request in idle begins a load of exactly L A/B pairs, A first in each pair. L is the effective chain length. The bit on `scan_in_i` during the j-th A pulse (j counted from 1) ends up in cell L-j, where cell 0 is the one next to the scan input. After the load, `l2_state_o[L-1:0]` holds the shifted pattern.
- R3: After the load, `pi_apply_o` goes high with all clocks off. It stays high until a one-cycle `pi_done_i`.
- R4: Next, `po_strobe_o` goes high with all clocks off. It stays high until a one-cycle `po_done_i`.
- R5: After the strobe, exactly one C pulse loads `sys_data_i` into every L1 latch. The L2 contents (`l2_state_o`) change only on B pulses, so they keep the loaded pattern after C.
- R6: After the capture, a single B pulse with no A pulse before it copies L1 into L2. `l2_state_o` then equals the captured data.
- R7: The unload issues exactly L A/B pairs. `scan_out_o` is the L2 of cell L-1, so during the j-th unload A pulse it shows the captured bit of cell L-j.
- R8: No two of the A, B and C enables are ever high in the same cycle.
- R9: Every clock pulse lasts one cycle. At least `GAP_CYCLES` cycles with no clock enable follow it.
- R10: `busy_o` is high from the cycle after start until `done_o`. `done_o` is high for exactly one cycle after the trailing gap of the last unload pair, and the block is idle in the next cycle.
- R11: A start request while busy is ignored. A run issues 2L A pulses, 2L+1 B pulses and one C pulse, and gives a single done.
- R12: `chain_len_i` is sampled only at start. A value of 0 is treated as 1, and a value above `CHAIN_MAX` is treated as `CHAIN_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one test pattern sequence |
| chain_len_i | input | LEN_W | Requested shift length, sampled at start |
| pi_done_i | input | 1 | Tester has applied primary inputs |
| po_done_i | input | 1 | Tester has strobed primary outputs |
| scan_in_i | input | 1 | Serial scan data into cell 0 |
| sys_data_i | input | CHAIN_MAX | Logic response captured into L1 by C |
| clk_a_o | output | 1 | Scan (master) clock enable |
| clk_b_o | output | 1 | Slave clock enable |
| clk_c_o | output | 1 | System clock enable |
| pi_apply_o | output | 1 | Request to apply primary inputs |
| po_strobe_o | output | 1 | Window for measuring primary outputs |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion flag |
| scan_out_o | output | 1 | L2 of the last active cell |
| l2_state_o | output | CHAIN_MAX | L2 contents of all cells |

## Verification
The bench builds the block with `CHAIN_MAX = 8` and `GAP_CYCLES = 2`. This selects the counter-based gap timer instead of the single-cycle shortcut, so R9 is checked against a real multi-cycle gap. With eight cells, the full-length chain and both clamp directions (a request of 0 and a request of 15) can be tested. The random runs mix lengths from 1 to 8 with handshake delays and start requests that arrive mid-run.

// File: rtl/lssd_seq_pkg.sv
package lssd_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_LD_A  = 4'd1,
      ST_LD_GA = 4'd2,
      ST_LD_B  = 4'd3,
      ST_LD_GB = 4'd4,
      ST_PI    = 4'd5,
      ST_PO    = 4'd6,
      ST_CAP_C = 4'd7,
      ST_CAP_G = 4'd8,
      ST_XFR_B = 4'd9,
      ST_XFR_G = 4'd10,
      ST_UL_A  = 4'd11,
      ST_UL_GA = 4'd12,
      ST_UL_B  = 4'd13,
      ST_UL_GB = 4'd14,
      ST_DONE  = 4'd15
   } seq_state_e;

   function automatic logic is_gap_state(seq_state_e s);
      return (s == ST_LD_GA) || (s == ST_LD_GB) || (s == ST_CAP_G) ||
             (s == ST_XFR_G) || (s == ST_UL_GA) || (s == ST_UL_GB);
   endfunction

endpackage

// File: rtl/lssd_gap_timer.sv
module lssd_gap_timer #(
   parameter int GAP_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_gap_i,
   output logic gap_done_o
);
   localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

   logic [CW-1:0] cnt_q;

   generate
      if (GAP_CYCLES < 2) begin : g_bad
         $error("lssd_gap_timer needs GAP_CYCLES of at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!in_gap_i)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign gap_done_o = in_gap_i && (cnt_q == CW'(GAP_CYCLES - 1));

   AST_GAP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_gap_i |-> (cnt_q <= CW'(GAP_CYCLES - 1))); // R9

endmodule

// File: rtl/lssd_seq_fsm.sv
module lssd_seq_fsm
   import lssd_seq_pkg::*;
#(
   parameter int CHAIN_MAX = 8,
   parameter int LEN_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] chain_len_i,
   input  logic             pi_done_i,
   input  logic             po_done_i,
   input  logic             gap_done_i,
   output logic [LEN_W-1:0] len_o,
   output logic             in_gap_o,
   output logic             clk_a_o,
   output logic             clk_b_o,
   output logic             clk_c_o,
   output logic             pi_apply_o,
   output logic             po_strobe_o,
   output logic             busy_o,
   output logic             done_o
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(CHAIN_MAX);

   seq_state_e       state_q, state_d;
   logic [LEN_W-1:0] len_q, len_d;
   logic [LEN_W-1:0] pair_q, pair_d;
   logic [LEN_W-1:0] len_clamped;
   logic             last_pair;

   always_comb begin
      if (chain_len_i == '0)
         len_clamped = LEN_W'(1);
      else if (chain_len_i > LEN_MAX)
         len_clamped = LEN_MAX;
      else
         len_clamped = chain_len_i;
   end

   assign last_pair = (pair_q == (len_q - LEN_W'(1)));

   always_comb begin
      state_d = state_q;
      len_d   = len_q;
      pair_d  = pair_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_LD_A;
               len_d   = len_clamped;
               pair_d  = '0;
            end
         end
         ST_LD_A:  state_d = ST_LD_GA;
         ST_LD_GA: if (gap_done_i) state_d = ST_LD_B;
         ST_LD_B:  state_d = ST_LD_GB;
         ST_LD_GB: begin
            if (gap_done_i) begin
               if (last_pair) begin
                  state_d = ST_PI;
                  pair_d  = '0;
               end else begin
                  state_d = ST_LD_A;
                  pair_d  = pair_q + LEN_W'(1);
               end
            end
         end
         ST_PI:    if (pi_done_i) state_d = ST_PO;
         ST_PO:    if (po_done_i) state_d = ST_CAP_C;
         ST_CAP_C: state_d = ST_CAP_G;
         ST_CAP_G: if (gap_done_i) state_d = ST_XFR_B;
         ST_XFR_B: state_d = ST_XFR_G;
         ST_XFR_G: if (gap_done_i) state_d = ST_UL_A;
         ST_UL_A:  state_d = ST_UL_GA;
         ST_UL_GA: if (gap_done_i) state_d = ST_UL_B;
         ST_UL_B:  state_d = ST_UL_GB;
         ST_UL_GB: begin
            if (gap_done_i) begin
               if (last_pair) begin
                  state_d = ST_DONE;
                  pair_d  = '0;
               end else begin
                  state_d = ST_UL_A;
                  pair_d  = pair_q + LEN_W'(1);
               end
            end
         end
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= LEN_W'(1);
         pair_q  <= '0;
      end else begin
         state_q <= state_d;
         len_q   <= len_d;
         pair_q  <= pair_d;
      end
   end

   assign clk_a_o     = (state_q == ST_LD_A) || (state_q == ST_UL_A);
   assign clk_b_o     = (state_q == ST_LD_B) || (state_q == ST_UL_B) ||
                        (state_q == ST_XFR_B);
   assign clk_c_o     = (state_q == ST_CAP_C);
   assign pi_apply_o  = (state_q == ST_PI);
   assign po_strobe_o = (state_q == ST_PO);
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign in_gap_o    = is_gap_state(state_q);
   assign len_o       = len_q;

   AST_PAIR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (pair_q < len_q)); // R2
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ((len_q != '0) && (len_q <= LEN_MAX))); // R12
   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(len_q)); // R12
   AST_PI_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (pi_apply_o && !pi_done_i) |=> pi_apply_o); // R3
   AST_PO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (po_strobe_o && !po_done_i) |=> po_strobe_o); // R4

endmodule

// File: rtl/lssd_srl_chain.sv
module lssd_srl_chain #(
   parameter int CHAIN_MAX = 8,
   parameter int LEN_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_a_i,
   input  logic                 en_b_i,
   input  logic                 en_c_i,
   input  logic                 scan_in_i,
   input  logic [CHAIN_MAX-1:0] sys_data_i,
   input  logic [LEN_W-1:0]     len_i,
   output logic [CHAIN_MAX-1:0] l2_o,
   output logic                 scan_out_o
);
   logic [CHAIN_MAX-1:0] l1_q;
   logic [CHAIN_MAX-1:0] l2_q;

   generate
      for (genvar i = 0; i < CHAIN_MAX; i++) begin : g_cell
         logic shift_src;
         if (i == 0) begin : g_head
            assign shift_src = scan_in_i;
         end else begin : g_body
            assign shift_src = l2_q[i-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               l1_q[i] <= 1'b0;
            else if (en_c_i)
               l1_q[i] <= sys_data_i[i];
            else if (en_a_i)
               l1_q[i] <= shift_src;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               l2_q[i] <= 1'b0;
            else if (en_b_i)
               l2_q[i] <= l1_q[i];
         end
      end
   endgenerate

   assign l2_o       = l2_q;
   assign scan_out_o = l2_q[len_i - LEN_W'(1)];

   AST_L2_ONLY_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
      !en_b_i |=> $stable(l2_q)); // R5
   AST_L1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_a_i || en_c_i) |=> $stable(l1_q)); // R6

endmodule

// File: rtl/lssd_clk_seq.sv
module lssd_clk_seq
   import lssd_seq_pkg::*;
#(
   parameter int  CHAIN_MAX  = 8,
   parameter int  GAP_CYCLES = 1,
   localparam int LEN_W      = $clog2(CHAIN_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [LEN_W-1:0]     chain_len_i,
   input  logic                 pi_done_i,
   input  logic                 po_done_i,
   input  logic                 scan_in_i,
   input  logic [CHAIN_MAX-1:0] sys_data_i,
   output logic                 clk_a_o,
   output logic                 clk_b_o,
   output logic                 clk_c_o,
   output logic                 pi_apply_o,
   output logic                 po_strobe_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 scan_out_o,
   output logic [CHAIN_MAX-1:0] l2_state_o
);
   logic [LEN_W-1:0] len_q;
   logic             in_gap;
   logic             gap_done;

   generate
      if (CHAIN_MAX < 1) begin : g_chk_len
         $error("CHAIN_MAX must be at least 1");
      end
      if (GAP_CYCLES < 1) begin : g_chk_gap
         $error("GAP_CYCLES must be at least 1");
      end

      if (GAP_CYCLES == 1) begin : g_gap_single
         assign gap_done = in_gap;
      end else begin : g_gap_count
         lssd_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_gap (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_gap_i  (in_gap),
            .gap_done_o(gap_done)
         );
      end
   endgenerate

   lssd_seq_fsm #(.CHAIN_MAX(CHAIN_MAX), .LEN_W(LEN_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .chain_len_i(chain_len_i),
      .pi_done_i  (pi_done_i),
      .po_done_i  (po_done_i),
      .gap_done_i (gap_done),
      .len_o      (len_q),
      .in_gap_o   (in_gap),
      .clk_a_o    (clk_a_o),
      .clk_b_o    (clk_b_o),
      .clk_c_o    (clk_c_o),
      .pi_apply_o (pi_apply_o),
      .po_strobe_o(po_strobe_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   lssd_srl_chain #(.CHAIN_MAX(CHAIN_MAX), .LEN_W(LEN_W)) i_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_a_i    (clk_a_o),
      .en_b_i    (clk_b_o),
      .en_c_i    (clk_c_o),
      .scan_in_i (scan_in_i),
      .sys_data_i(sys_data_i),
      .len_i     (len_q),
      .l2_o      (l2_state_o),
      .scan_out_o(scan_out_o)
   );

   AST_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({clk_a_o, clk_b_o, clk_c_o}) <= 1); // R8
   AST_CLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_a_o || clk_b_o || clk_c_o) |=> !(clk_a_o || clk_b_o || clk_c_o)); // R9
   AST_HS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pi_apply_o || po_strobe_o) |-> !(clk_a_o || clk_b_o || clk_c_o)); // R3
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o)); // R10
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && clk_a_o)); // R2

endmodule

// File: tb/test_lssd_clk_seq.sv
module test_lssd_clk_seq;
   localparam int CHAIN_MAX  = 8;
   localparam int GAP_CYCLES = 2;
   localparam int LEN_W      = $clog2(CHAIN_MAX + 1);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start_i = 1'b0;
   logic [LEN_W-1:0]     chain_len_i = '0;
   logic                 pi_done_i = 1'b0;
   logic                 po_done_i = 1'b0;
   logic                 scan_in_i = 1'b0;
   logic [CHAIN_MAX-1:0] sys_data_i = '0;
   logic                 clk_a_o, clk_b_o, clk_c_o;
   logic                 pi_apply_o, po_strobe_o, busy_o, done_o, scan_out_o;
   logic [CHAIN_MAX-1:0] l2_state_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int last_pulse = -100;
   int cnt_a = 0, cnt_b = 0, cnt_c = 0, cnt_done = 0;

   always #2 clk = ~clk;

   lssd_clk_seq #(.CHAIN_MAX(CHAIN_MAX), .GAP_CYCLES(GAP_CYCLES)) i_lssd_clk_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_len_i(chain_len_i),
      .pi_done_i(pi_done_i), .po_done_i(po_done_i), .scan_in_i(scan_in_i),
      .sys_data_i(sys_data_i), .clk_a_o(clk_a_o), .clk_b_o(clk_b_o),
      .clk_c_o(clk_c_o), .pi_apply_o(pi_apply_o), .po_strobe_o(po_strobe_o),
      .busy_o(busy_o), .done_o(done_o), .scan_out_o(scan_out_o),
      .l2_state_o(l2_state_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: clock exclusivity (R8) and idle gap after each pulse (R9)
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (clk_a_o) cnt_a <= cnt_a + 1;
         if (clk_b_o) cnt_b <= cnt_b + 1;
         if (clk_c_o) cnt_c <= cnt_c + 1;
         if (done_o)  cnt_done <= cnt_done + 1;
         if (clk_a_o || clk_b_o || clk_c_o) begin
            if ((32'(clk_a_o) + 32'(clk_b_o) + 32'(clk_c_o)) > 1)
               check(1'b0, "R8", 32'(clk_a_o) + 32'(clk_b_o) + 32'(clk_c_o), 1);
            if ((cyc - last_pulse) < GAP_CYCLES + 1)
               check(1'b0, "R9", cyc - last_pulse, GAP_CYCLES + 1);
            last_pulse <= cyc;
         end
      end
   end

   always @(negedge clk) begin
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   function automatic int eff_len(input int req);
      if (req == 0) return 1;
      if (req > CHAIN_MAX) return CHAIN_MAX;
      return req;
   endfunction

   task automatic run_pattern(input int req_len, input logic [CHAIN_MAX-1:0] pat,
                              input logic [CHAIN_MAX-1:0] cap, input bit poke_start);
      int L = eff_len(req_len);
      logic [CHAIN_MAX-1:0] mask = CHAIN_MAX'((1 << L) - 1);
      int a0, b0, c0, d0;
      a0 = cnt_a; b0 = cnt_b; c0 = cnt_c; d0 = cnt_done;

      @(negedge clk);
      chain_len_i = LEN_W'(req_len);
      scan_in_i   = pat[L-1];
      start_i     = 1'b1;
      @(negedge clk);
      start_i     = 1'b0;
      chain_len_i = LEN_W'($urandom_range(0, (1 << LEN_W) - 1)); // R12: ignored now
      check(busy_o === 1'b1, "R10 busy", busy_o, 1);

      for (int j = 1; j <= L; j++) begin
         scan_in_i = pat[L-j];
         while (!clk_a_o) @(negedge clk);
         @(negedge clk);
      end

      while (!pi_apply_o) @(negedge clk);
      check((l2_state_o & mask) == (pat & mask), "R2 load", int'(l2_state_o & mask), int'(pat & mask));
      check((cnt_a - a0) == L && (cnt_b - b0) == L, "R2 pairs", cnt_a - a0, L);
      for (int k = 0; k < int'($urandom_range(1, 4)); k++) begin
         @(negedge clk);
         check(pi_apply_o && !(clk_a_o || clk_b_o || clk_c_o), "R3 hold", pi_apply_o, 1);
      end
      pi_done_i = 1'b1;
      @(negedge clk);
      pi_done_i = 1'b0;

      check(po_strobe_o === 1'b1, "R4 strobe", po_strobe_o, 1);
      sys_data_i = cap;
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
         @(negedge clk);
         check(po_strobe_o && !(clk_a_o || clk_b_o || clk_c_o), "R4 hold", po_strobe_o, 1);
      end
      po_done_i = 1'b1;
      @(negedge clk);
      po_done_i = 1'b0;

      while (!clk_c_o) @(negedge clk);
      @(negedge clk);
      check((l2_state_o & mask) == (pat & mask), "R5 l2 kept", int'(l2_state_o & mask), int'(pat & mask));
      while (!clk_b_o) @(negedge clk);
      check((cnt_a - a0) == L, "R6 no A before copy", cnt_a - a0, L);
      @(negedge clk);
      check(l2_state_o == cap, "R6 copy", int'(l2_state_o), int'(cap));

      for (int j = 1; j <= L; j++) begin
         while (!clk_a_o) @(negedge clk);
         check(scan_out_o == cap[L-j], "R7 unload bit", scan_out_o, cap[L-j]);
         if (poke_start && j == 1) start_i = 1'b1; // R11
         @(negedge clk);
         start_i = 1'b0;
      end

      while (!done_o) @(negedge clk);
      @(negedge clk);
      check(!done_o && !busy_o, "R10 done single", done_o, 0);
      repeat (4) @(negedge clk);
      check((cnt_a - a0) == 2 * L, "R11 A count", cnt_a - a0, 2 * L);
      check((cnt_b - b0) == 2 * L + 1, "R11 B count", cnt_b - b0, 2 * L + 1);
      check((cnt_c - c0) == 1, "R11 C count", cnt_c - c0, 1);
      check((cnt_done - d0) == 1 && !busy_o, "R11 one done", cnt_done - d0, 1);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(!clk_a_o && !clk_b_o && !clk_c_o && !pi_apply_o && !po_strobe_o &&
            !busy_o && !done_o, "R1 reset", busy_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !clk_a_o, "R1 idle", busy_o, 0);

      run_pattern(1, 8'h01, 8'h01, 1'b0);
      run_pattern(CHAIN_MAX, 8'hB4, 8'h5D, 1'b1);
      run_pattern(0, 8'h01, 8'hFE, 1'b0);   // R12 zero -> one
      run_pattern(15, 8'h3C, 8'hA7, 1'b1);  // R12 above max -> CHAIN_MAX
      for (int r = 0; r < 20; r++)
         run_pattern($urandom_range(1, CHAIN_MAX), CHAIN_MAX'($urandom),
                     CHAIN_MAX'($urandom), 1'($urandom_range(0, 1)));

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule